// File: doc/BRIEF.md
# Iterative Bitsliced 128-bit Block Cipher Core

This core encrypts or decrypts one 128-bit block per request. The block is held as four 32-bit words, and the core runs one round per clock. Each round mixes in a 128-bit round key and then passes every bit column of the four words through a 4-bit substitution box. Every round except the last then runs a word-level diffusion step. The box changes each round with the round index modulo eight. Decryption walks the keys in reverse and uses the inverse boxes and the inverse diffusion. The 33 round keys are computed outside the core. They are written one 32-bit word at a time into an internal key store before any block is started.

Blocks enter through a valid/ready handshake. `in_ready` is high only while the core is idle, so a producer holding `in_valid` simply waits until the core is idle. The result leaves through a second valid/ready pair. `out_valid` and `out_data` stay fixed until the consumer raises `out_ready`, and the core takes no new block until that handshake has completed. With `out_ready` tied high, `out_valid` is a one-cycle done pulse. The key write port is a plain strobe with no handshake.

Top module: `bitslice_cipher`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is all zeros.
- R2: The key store holds 132 words. Key i, word j is written at address 4*i+j and is XORed into data word j, which is `in_data`/`out_data` bits [32j+31:32j]. A write to an address of 132 or above changes nothing. A write made while idle is used by the next block. No write may occur while a block is in flight.
- R3: Encryption runs rounds r = 0..31. Each round XORs key r, then applies box (r mod 8), then the diffusion step of R4, except that round 31 XORs key 32 in place of the diffusion. The box input nibble for bit column k takes bit j from bit k of word j. Each box is a 64-bit constant whose bits [4n+3:4n] give the output for input n. The constants for boxes 0..7 are C90724DEB56A1F83, 43D68EB1A50972CF, 25B04E1DFAC39768, E57A421D369C8BF0, D7E9A4526B0C38F1, 176D8E30C9A4B25F, 0A3DF19EB6485C27 and 6539AC47B28E0FD1.
- R4: The diffusion on words (a,b,c,d) = words (0,1,2,3) is the following sequence of steps. Rotate a left 13 and c left 3. Set b ^= a^c and d ^= c^(a<<3). Rotate b left 1 and d left 7. Set a ^= b^d and c ^= d^(b<<7). Rotate a left 5 and c left 22.
- R5: Decryption (mode 1) is the exact inverse of R3. Decrypting a ciphertext returns its plaintext, and encrypting the result of decrypting any block returns that block.
- R6: `out_valid` rises exactly 33 clock cycles after the edge that accepts a block, in both modes.
- R7: From acceptance until the result has been taken, `in_ready` is 0. Any `in_valid`, `in_data` or `in_mode` activity during that time has no effect on the result.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. After the cycle in which both are 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| kw_en | input | 1 | Key word write strobe |
| kw_addr | input | 8 | Key word address (4*key + word) |
| kw_data | input | 32 | Key word value |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Core idle and taking a block |
| in_mode | input | 1 | 0 encrypt, 1 decrypt; sampled at acceptance |
| in_data | input | 128 | Input block, word j at bits [32j+31:32j] |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result block, same word layout |

## Verification
The assertions check the handshake and sequencing on every cycle. They cover the following:
- `in_ready` drops after acceptance.
- The step counter stays within its 33 steps.
- `out_valid` rises only after the final step.
- The mode holds steady during a run.
- The result is frozen under back-pressure.
- The key port is quiet while a block is in flight.

The cipher arithmetic is shown only by the bench scenarios. These compare ciphertexts with an independent model over a table of plaintext patterns, check that each decryption round-trips, and confirm that disturbances while busy, rewritten key words and out-of-range key writes have the required effect or none.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int ROUNDS    = 32;
  localparam int NKEYS     = ROUNDS + 1;
  localparam int KEY_WORDS = NKEYS * BLK_WORDS;
  localparam int KADDR_W   = $clog2(KEY_WORDS);
  localparam int STEP_W    = $clog2(NKEYS);
  localparam int NBOX      = 8;
  localparam int BOX_W     = $clog2(NBOX);

  typedef logic [BLK_WORDS-1:0][WORD_W-1:0] blk_t;
  typedef enum logic {DIR_ENC = 1'b0, DIR_DEC = 1'b1} dir_e;

  // Output nibble for input n sits at bits [4n+3:4n].
  localparam logic [63:0] FWD_BOX [NBOX] = '{
    64'hC90724DEB56A1F83, 64'h43D68EB1A50972CF,
    64'h25B04E1DFAC39768, 64'hE57A421D369C8BF0,
    64'hD7E9A4526B0C38F1, 64'h176D8E30C9A4B25F,
    64'h0A3DF19EB6485C27, 64'h6539AC47B28E0FD1
  };

  function automatic logic [63:0] invert_box(input logic [63:0] t);
    logic [63:0] r;
    logic [3:0]  v;
    r = '0;
    for (int n = 0; n < 16; n++) begin
      v = t[{n[3:0], 2'b00} +: 4];
      r[{v, 2'b00} +: 4] = n[3:0];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  function automatic blk_t mix_fwd(input blk_t x);
    logic [WORD_W-1:0] a, b, c, d;
    a = rotl(x[0], 13);
    c = rotl(x[2], 3);
    b = x[1] ^ a ^ c;
    d = x[3] ^ c ^ (a << 3);
    b = rotl(b, 1);
    d = rotl(d, 7);
    a = a ^ b ^ d;
    c = c ^ d ^ (b << 7);
    a = rotl(a, 5);
    c = rotl(c, 22);
    return {d, c, b, a};
  endfunction

  function automatic blk_t mix_inv(input blk_t x);
    logic [WORD_W-1:0] a, b, c, d;
    b = x[1];
    d = x[3];
    c = rotr(x[2], 22);
    a = rotr(x[0], 5);
    c = c ^ d ^ (b << 7);
    a = a ^ b ^ d;
    d = rotr(d, 7);
    b = rotr(b, 1);
    d = d ^ c ^ (a << 3);
    b = b ^ a ^ c;
    c = rotr(c, 3);
    a = rotr(a, 13);
    return {d, c, b, a};
  endfunction
endpackage

// File: rtl/bsc_keystore.sv
module bsc_keystore
  import bsc_pkg::*;
(
  input  logic               clk,
  input  logic               wr_en,
  input  logic [KADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [STEP_W-1:0]  rd_idx,
  output blk_t               rd_key
);
  logic [WORD_W-1:0] mem [KEY_WORDS];

  // R2: addresses beyond the store are dropped
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < KADDR_W'(KEY_WORDS)))
      mem[wr_addr] <= wr_data;
  end

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_rd
    logic [KADDR_W-1:0] addr;
    assign addr = KADDR_W'(rd_idx) * KADDR_W'(BLK_WORDS) + KADDR_W'(j);
    assign rd_key[j] = mem[addr];
  end
endmodule

// File: rtl/bsc_round.sv
module bsc_round
  import bsc_pkg::*;
(
  input  blk_t              cur,
  input  blk_t              rkey,
  input  dir_e              dir,
  input  logic [STEP_W-1:0] step,
  output blk_t              nxt
);
  logic [63:0] inv_tbl [NBOX];
  for (genvar b = 0; b < NBOX; b++) begin : g_inv
    assign inv_tbl[b] = invert_box(FWD_BOX[b]);
  end

  blk_t              kx, sub_in, sub_out;
  logic [63:0]       tbl;
  logic [BOX_W-1:0]  box_sel;
  logic [STEP_W-1:0] rev_step;

  always_comb begin
    kx       = cur ^ rkey;
    rev_step = STEP_W'(ROUNDS) - step;
    if (dir == DIR_ENC) begin
      box_sel = step[BOX_W-1:0];
      sub_in  = kx;
      tbl     = FWD_BOX[box_sel];
    end else begin
      box_sel = rev_step[BOX_W-1:0];
      sub_in  = (step == STEP_W'(1)) ? cur : mix_inv(cur);
      tbl     = inv_tbl[box_sel];
    end
  end

  // One shared lookup per bit column, table picked above
  logic [3:0] col_out [WORD_W];
  for (genvar k = 0; k < WORD_W; k++) begin : g_col
    logic [3:0] col_in;
    assign col_in     = {sub_in[3][k], sub_in[2][k], sub_in[1][k], sub_in[0][k]};
    assign col_out[k] = tbl[{col_in, 2'b00} +: 4];
  end

  always_comb begin
    for (int k = 0; k < WORD_W; k++)
      for (int j = 0; j < BLK_WORDS; j++)
        sub_out[j][k] = col_out[k][j];
  end

  always_comb begin
    if (dir == DIR_ENC) begin
      if (step == STEP_W'(ROUNDS))          nxt = kx;
      else if (step == STEP_W'(ROUNDS - 1)) nxt = sub_out;
      else                                  nxt = mix_fwd(sub_out);
    end else begin
      if (step == '0) nxt = kx;
      else            nxt = sub_out ^ rkey;
    end
  end
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  input  dir_e              dir_in,
  output logic              accept,
  output logic              advance,
  output dir_e              dir,
  output logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] key_idx
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} st_e;
  st_e state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign advance   = (state == ST_RUN);
  assign key_idx   = (dir == DIR_ENC) ? step : STEP_W'(ROUNDS) - step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      dir   <= DIR_ENC;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          step  <= '0;
          dir   <= dir_in;
        end
        ST_RUN: if (step == STEP_W'(ROUNDS)) state <= ST_HOLD;
                else step <= step + 1'b1;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> step <= STEP_W'(ROUNDS));
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(advance) && $past(step) == STEP_W'(ROUNDS)));
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
  a_r7_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && $past(advance)) |-> $stable(dir));
endmodule

// File: rtl/bitslice_cipher.sv
module bitslice_cipher
  import bsc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          kw_en,
  input  logic [KADDR_W-1:0]            kw_addr,
  input  logic [WORD_W-1:0]             kw_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_mode,
  input  logic [BLK_WORDS*WORD_W-1:0]   in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BLK_WORDS*WORD_W-1:0]   out_data
);
  logic              accept, advance;
  dir_e              dir;
  logic [STEP_W-1:0] step, key_idx;
  blk_t              rkey, state_q, state_d;

  bsc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .dir_in   (dir_e'(in_mode)),
    .accept   (accept),
    .advance  (advance),
    .dir      (dir),
    .step     (step),
    .key_idx  (key_idx)
  );

  bsc_keystore u_keys (
    .clk    (clk),
    .wr_en  (kw_en),
    .wr_addr(kw_addr),
    .wr_data(kw_data),
    .rd_idx (key_idx),
    .rd_key (rkey)
  );

  bsc_round u_round (
    .cur (state_q),
    .rkey(rkey),
    .dir (dir),
    .step(step),
    .nxt (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (accept)  state_q <= blk_t'(in_data);
    else if (advance) state_q <= state_d;
  end

  assign out_data = state_q;

  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  a_r2_keys_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !out_valid) |-> !kw_en);
endmodule

// File: tb/test_bitslice_cipher.sv
`timescale 1ns/1ps
module test_bitslice_cipher;
  logic         clk = 0, rst_n = 0;
  logic         kw_en = 0;
  logic [7:0]   kw_addr = '0;
  logic [31:0]  kw_data = '0;
  logic         in_valid = 0, in_mode = 0, out_ready = 0;
  logic [127:0] in_data = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitslice_cipher i_bitslice_cipher (
    .clk(clk), .rst_n(rst_n), .kw_en(kw_en), .kw_addr(kw_addr), .kw_data(kw_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  localparam logic [63:0] TB_BOX [8] = '{
    64'hC90724DEB56A1F83, 64'h43D68EB1A50972CF, 64'h25B04E1DFAC39768, 64'hE57A421D369C8BF0,
    64'hD7E9A4526B0C38F1, 64'h176D8E30C9A4B25F, 64'h0A3DF19EB6485C27, 64'h6539AC47B28E0FD1
  };

  localparam logic [127:0] VEC [6] = '{
    128'h0,
    {128{1'b1}},
    128'h1,
    128'h80000000_00000000_00000000_00000000,
    128'h01234567_89ABCDEF_FEDCBA98_76543210,
    128'hDEADBEEF_00FF00FF_A5A5A5A5_13579BDF
  };

  logic [31:0] kmem [132];

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [127:0] tkey(input int i);
    return {kmem[4*i+3], kmem[4*i+2], kmem[4*i+1], kmem[4*i]};
  endfunction

  function automatic logic [127:0] tsub(input logic [127:0] v, input int b);
    logic [127:0] r;
    logic [3:0]   n, o;
    for (int k = 0; k < 32; k++) begin
      n = {v[96+k], v[64+k], v[32+k], v[k]};
      o = TB_BOX[b][n*4 +: 4];
      r[k] = o[0]; r[32+k] = o[1]; r[64+k] = o[2]; r[96+k] = o[3];
    end
    return r;
  endfunction

  function automatic logic [127:0] tlin(input logic [127:0] v);
    logic [31:0] w0, w1, w2, w3;
    w0 = rl(v[31:0], 13); w2 = rl(v[95:64], 3);
    w1 = v[63:32] ^ w0 ^ w2; w3 = v[127:96] ^ w2 ^ (w0 << 3);
    w1 = rl(w1, 1); w3 = rl(w3, 7);
    w0 = w0 ^ w1 ^ w3; w2 = w2 ^ w3 ^ (w1 << 7);
    w0 = rl(w0, 5); w2 = rl(w2, 22);
    return {w3, w2, w1, w0};
  endfunction

  function automatic logic [127:0] tenc(input logic [127:0] p);
    logic [127:0] v = p;
    for (int r = 0; r < 32; r++) begin
      v = tsub(v ^ tkey(r), r % 8);
      if (r < 31) v = tlin(v);
      else        v = v ^ tkey(32);
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_key(input int a, input logic [31:0] d);
    @(negedge clk); kw_en = 1; kw_addr = a[7:0]; kw_data = d;
    @(negedge clk); kw_en = 0;
  endtask

  task automatic run_block(input logic mode, input logic [127:0] d, input bit disturb,
                           output logic [127:0] res, output int lat, output bit busy_low);
    @(negedge clk); in_valid = 1; in_mode = mode; in_data = d;
    @(posedge clk);
    @(negedge clk); in_valid = 0; lat = 0; busy_low = 1;
    while (!out_valid) begin
      if (in_ready) busy_low = 0;
      if (disturb) begin in_valid = 1; in_data = ~d; in_mode = ~mode; end
      @(negedge clk); lat++;
    end
    in_valid = 0;
    res = out_data;
  endtask

  task automatic drain();
    out_ready = 1;
    @(negedge clk); out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] ct, pt, res, held;
    int lat;
    bit bl;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 in_ready", 128'(in_ready), 128'(1));
    check("R1 out_valid", 128'(out_valid), 128'(0));
    check("R1 out_data", out_data, 128'h0);

    for (int i = 0; i < 132; i++) begin
      kmem[i] = (32'(i) << 11) ^ (32'h9E3779B9 * 32'(i + 1));
      put_key(i, kmem[i]);
    end

    // Table walk: encryption vs model, latency, round trip
    for (int i = 0; i < 6; i++) begin
      run_block(1'b0, VEC[i], 1'b0, ct, lat, bl);
      check("R3 R4 encrypt", ct, tenc(VEC[i]));
      check("R6 encrypt latency", 128'(lat), 128'(33));
      check("R7 busy in_ready", 128'(bl), 128'(1));
      drain();
      run_block(1'b1, ct, 1'b0, pt, lat, bl);
      check("R5 decrypt round trip", pt, VEC[i]);
      check("R6 decrypt latency", 128'(lat), 128'(33));
      drain();
    end

    // R5: encrypting the decryption of an arbitrary block returns it
    run_block(1'b1, 128'hCAFEF00D_12345678_0BADC0DE_55AA33CC, 1'b0, pt, lat, bl);
    drain();
    check("R5 enc of dec", tenc(pt), 128'hCAFEF00D_12345678_0BADC0DE_55AA33CC);

    // R8: back-pressure holds the result
    run_block(1'b0, VEC[4], 1'b0, ct, lat, bl);
    held = out_data;
    repeat (5) @(negedge clk);
    check("R8 valid held", 128'(out_valid), 128'(1));
    check("R8 data held", out_data, held);
    check("R7 not ready while holding", 128'(in_ready), 128'(0));
    drain();
    check("R8 released valid", 128'(out_valid), 128'(0));
    check("R8 ready returns", 128'(in_ready), 128'(1));

    // R7: input activity while busy has no effect
    run_block(1'b0, VEC[5], 1'b1, ct, lat, bl);
    check("R7 disturbed result", ct, tenc(VEC[5]));
    check("R7 stays busy", 128'(bl), 128'(1));
    drain();

    // R2: rewritten word lands at 4*key+word and is used next block
    kmem[4*5+2] = 32'h0F1E2D3C;
    put_key(4*5+2, kmem[4*5+2]);
    run_block(1'b0, VEC[4], 1'b0, ct, lat, bl);
    check("R2 rewritten key", ct, tenc(VEC[4]));
    drain();

    // R2: writes beyond the store are ignored
    put_key(132, 32'hFFFFFFFF);
    put_key(200, 32'h12345678);
    put_key(255, 32'hA5A5A5A5);
    run_block(1'b0, VEC[4], 1'b0, ct, lat, bl);
    check("R2 out of range ignored", ct, tenc(VEC[4]));
    drain();
    run_block(1'b1, ct, 1'b0, pt, lat, bl);
    check("R2 R5 round trip after writes", pt, VEC[4]);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule